// File: doc/BRIEF.md
# Reservation Monitor for Linked Load / Conditional Store

This block places a single-address reservation tracker in front of a small word memory so that a processor port can perform an atomic read-modify-write as a pair of operations. A linked load returns a word and arms a reservation on its address. A later conditional store to that address writes only if nothing has written the word in the meantime. It returns 1 when it writes and 0 when the write is suppressed.

The memory is shared with a second agent. That agent's writes arrive on a snoop write bus: they update the memory and break any reservation on the address they touch. Local plain stores also break a reservation on their own address.

Every accepted request produces a response one clock later. For loads the response carries the word as it was before any write in the request cycle. For a conditional store it carries the 0/1 status. For a plain store it carries zero.

Top module: `llsc_monitor`

## Requirements
- R1: Reset clears every memory word to zero and drops the reservation. `rsp_valid_o` is 0 while reset is held, and a conditional store issued first after reset returns 0.
- R2: A request accepted at clock edge t raises `rsp_valid_o` for exactly the cycle after edge t. A load (op 2'b00) returns the word held before any write of that same cycle.
- R3: A plain store (op 2'b01) writes the word and responds with data 0.
- R4: A linked load (op 2'b10) returns the word and arms a reservation on its address.
- R5: A conditional store (op 2'b11) whose address matches an armed reservation writes the word and responds with 1.
- R6: A failing conditional store leaves memory unchanged and responds with 0.
- R7: Every conditional store disarms the reservation, whether it succeeds or fails.
- R8: A conditional store to an address other than the reserved one fails.
- R9: A local plain store to the reserved address disarms the reservation. A plain store to any other address leaves it armed.
- R10: A snoop write to the reserved address updates memory and disarms the reservation. A snoop write to another address leaves it armed.
- R11: When a snoop write and a local write hit the same address in one cycle, the snoop write counts as earlier. A conditional store in that cycle fails, so the snoop data stays in memory. A plain store in that cycle lands last, so the local data stays in memory.
- R12: A new linked load replaces any earlier reservation.
- R13: A linked load that meets a snoop write to its own address in the same cycle returns the old word and arms no reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Local request valid |
| req_op_i | input | 2 | 00 load, 01 store, 10 linked load, 11 conditional store |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | DW | Write data for the store operations |
| snoop_we_i | input | 1 | Write strobe from the other agent |
| snoop_addr_i | input | AW | Address of the other agent's write |
| snoop_wdata_i | input | DW | Data of the other agent's write |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rdata_o | output | DW | Load data, or 0/1 status for a conditional store |

## Verification
The hardest situations to reach are the same-cycle collisions. One is a snoop write landing on the reserved address in exactly the cycle of the conditional store. Another is a snoop write meeting a linked load to the same address. Directed sequences arm a reservation, then drive the snoop bus and the local request together on one falling edge so that both reach the same rising edge. A follow-up load then shows which data survived. A randomized phase confined to four addresses makes these overlaps frequent and is checked every cycle against a behavioural model.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LINK  = 2'b10,
    OP_COND  = 2'b11
  } llsc_op_e;
endpackage

// File: rtl/llsc_mem.sv
module llsc_mem #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          early_we_i,
  input  logic [AW-1:0] early_addr_i,
  input  logic [DW-1:0] early_data_i,
  input  logic          late_we_i,
  input  logic [AW-1:0] late_addr_i,
  input  logic [DW-1:0] late_data_i
);
  localparam int Depth = 1 << AW;

  logic [DW-1:0] words_q [Depth];

  for (genvar g = 0; g < Depth; g++) begin : g_word
    logic hit_early, hit_late;
    assign hit_early = early_we_i && (early_addr_i == AW'(g));
    assign hit_late  = late_we_i  && (late_addr_i  == AW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        words_q[g] <= '0;
      else if (hit_late)  words_q[g] <= late_data_i;  // later write wins
      else if (hit_early) words_q[g] <= early_data_i;
    end
  end

  assign rd_data_o = words_q[rd_addr_i];
endmodule

// File: rtl/llsc_resv.sv
module llsc_resv #(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] req_addr_i,
  input  logic          link_i,
  input  logic          cond_i,
  input  logic          store_i,
  input  logic          snoop_we_i,
  input  logic [AW-1:0] snoop_addr_i,
  output logic          cond_ok_o,
  output logic          valid_o,
  output logic [AW-1:0] addr_o
);
  logic          valid_q;
  logic [AW-1:0] addr_q;
  logic          snoop_on_resv, snoop_on_req, store_on_resv;

  assign snoop_on_resv = snoop_we_i && (snoop_addr_i == addr_q);
  assign snoop_on_req  = snoop_we_i && (snoop_addr_i == req_addr_i);
  assign store_on_resv = store_i && (req_addr_i == addr_q);

  // snoop write ordered before the local access of the same cycle
  assign cond_ok_o = valid_q && (addr_q == req_addr_i) && !snoop_on_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else if (link_i) begin
      valid_q <= !snoop_on_req;
      addr_q  <= req_addr_i;
    end else if (cond_i || snoop_on_resv || store_on_resv) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [1:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          snoop_we_i,
  input  logic [AW-1:0] snoop_addr_i,
  input  logic [DW-1:0] snoop_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rdata_o
);
  import llsc_pkg::*;

  llsc_op_e      op;
  logic          is_load, is_store, is_link, is_cond;
  logic          cond_ok, local_we;
  logic          resv_valid;
  logic [AW-1:0] resv_addr;
  logic [DW-1:0] mem_rdata, rsp_data_d;
  logic          rsp_valid_q;
  logic [DW-1:0] rdata_q;

  assign op       = llsc_op_e'(req_op_i);
  assign is_load  = req_valid_i && (op == OP_LOAD);
  assign is_store = req_valid_i && (op == OP_STORE);
  assign is_link  = req_valid_i && (op == OP_LINK);
  assign is_cond  = req_valid_i && (op == OP_COND);
  assign local_we = is_store || (is_cond && cond_ok);

  llsc_resv #(.AW(AW)) u_resv (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_addr_i   (req_addr_i),
    .link_i       (is_link),
    .cond_i       (is_cond),
    .store_i      (is_store),
    .snoop_we_i   (snoop_we_i),
    .snoop_addr_i (snoop_addr_i),
    .cond_ok_o    (cond_ok),
    .valid_o      (resv_valid),
    .addr_o       (resv_addr)
  );

  llsc_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_addr_i    (req_addr_i),
    .rd_data_o    (mem_rdata),
    .early_we_i   (snoop_we_i),
    .early_addr_i (snoop_addr_i),
    .early_data_i (snoop_wdata_i),
    .late_we_i    (local_we),
    .late_addr_i  (req_addr_i),
    .late_data_i  (req_wdata_i)
  );

  always_comb begin
    rsp_data_d = '0;
    if (is_load || is_link) rsp_data_d = mem_rdata;
    else if (is_cond)       rsp_data_d = DW'(cond_ok);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
    end else begin
      rsp_valid_q <= req_valid_i;
      rdata_q     <= rsp_data_d;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic [1:0]    req_op_i,
  input logic [AW-1:0] req_addr_i,
  input logic          snoop_we_i,
  input logic [AW-1:0] snoop_addr_i,
  input logic          rsp_valid_o,
  input logic [DW-1:0] rdata_o,
  input logic          resv_valid,
  input logic [AW-1:0] resv_addr
);
  a_r2_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  a_r2_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  a_r4_link_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 2'b10 && !(snoop_we_i && snoop_addr_i == req_addr_i))
    |=> (resv_valid && resv_addr == $past(req_addr_i)));

  a_r13_link_collision: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 2'b10 && snoop_we_i && snoop_addr_i == req_addr_i)
    |=> !resv_valid);

  a_r7_cond_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 2'b11) |=> !resv_valid);

  a_r8_cond_mismatch_fails: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 2'b11 && (!resv_valid || resv_addr != req_addr_i))
    |=> (rdata_o == '0));

  a_r5_cond_status_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 2'b11) |=> (rdata_o[DW-1:1] == '0));

  a_r10_snoop_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snoop_we_i && resv_valid && snoop_addr_i == resv_addr
     && !(req_valid_i && req_op_i == 2'b10)) |=> !resv_valid);

  a_r3_store_zero_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 2'b01) |=> (rdata_o == '0));
endmodule

bind llsc_monitor llsc_monitor_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_op_i     (req_op_i),
  .req_addr_i   (req_addr_i),
  .snoop_we_i   (snoop_we_i),
  .snoop_addr_i (snoop_addr_i),
  .rsp_valid_o  (rsp_valid_o),
  .rdata_o      (rdata_o),
  .resv_valid   (resv_valid),
  .resv_addr    (resv_addr)
);

// File: tb/tb_llsc_monitor.sv
`timescale 1ns/1ps
module tb_llsc_monitor;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int DEPTH = 1 << AW;
  localparam logic [1:0] LD = 2'b00, ST = 2'b01, LL = 2'b10, SC = 2'b11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          snoop_we = 1'b0;
  logic [AW-1:0] snoop_addr = '0;
  logic [DW-1:0] snoop_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rdata;

  int checks = 0;
  int fails  = 0;

  // behavioural reference
  logic [DW-1:0] m_mem [DEPTH];
  bit            m_rv;
  int            m_ra;

  always #10 clk = ~clk;

  llsc_monitor #(.AW(AW), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .snoop_we_i(snoop_we), .snoop_addr_i(snoop_addr),
    .snoop_wdata_i(snoop_wdata), .rsp_valid_o(rsp_valid), .rdata_o(rdata)
  );

  task automatic check(string tag, logic ev, logic [DW-1:0] ed);
    checks++;
    if (rsp_valid !== ev || rdata !== ed) begin
      fails++;
      $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
               tag, rsp_valid, rdata, ev, ed);
    end
  endtask

  // drive one cycle at negedge, model it, check response at next negedge
  task automatic step(string tag, bit v, logic [1:0] op, int a, logic [DW-1:0] d,
                      bit swe = 0, int sa = 0, logic [DW-1:0] sd = '0);
    logic [DW-1:0] ed;
    bit ok;
    req_valid = v; req_op = op; req_addr = AW'(a); req_wdata = d;
    snoop_we = swe; snoop_addr = AW'(sa); snoop_wdata = sd;
    ed = '0;
    ok = m_rv && m_ra == a && !(swe && sa == a);
    if (v && (op == LD || op == LL)) ed = m_mem[a];
    else if (v && op == SC)          ed = DW'(ok);
    if (swe) m_mem[sa] = sd;
    if (v && (op == ST || (op == SC && ok))) m_mem[a] = d;
    if (swe && m_rv && sa == m_ra) m_rv = 0;
    if (v) begin
      case (op)
        LL: begin m_rv = !(swe && sa == a); m_ra = a; end
        SC: m_rv = 0;
        ST: if (m_rv && m_ra == a) m_rv = 0;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; snoop_we = 0;
    check(tag, v, ed);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: valid=x data=x expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    m_rv = 0; m_ra = 0;
    repeat (3) @(negedge clk);
    check("R1 reset valid low", 1'b0, '0);
    rst_n = 1'b1;
    @(negedge clk);
    step("R1 load after reset", 1, LD, 3, '0);
    step("R1 cond after reset", 1, SC, 3, 32'h11);
    step("R1 idle", 0, LD, 0, '0);
    step("R3 store", 1, ST, 5, 32'h0000_00AA);
    step("R2 load", 1, LD, 5, '0);
    step("R4 link", 1, LL, 5, '0);
    step("R5 cond ok", 1, SC, 5, 32'hCAFE_0001);
    step("R5 load new", 1, LD, 5, '0);
    step("R7 cond again fails", 1, SC, 5, 32'h1);
    step("R6 unchanged", 1, LD, 5, '0);
    step("R4 link", 1, LL, 5, '0);
    step("R8 cond other addr", 1, SC, 6, 32'h66);
    step("R6 no write", 1, LD, 6, '0);
    step("R7 cond after mismatch", 1, SC, 5, 32'h55);
    step("R4 link", 1, LL, 2, '0);
    step("R9 store other", 1, ST, 3, 32'h33);
    step("R9 cond ok", 1, SC, 2, 32'h22);
    step("R4 link", 1, LL, 2, '0);
    step("R9 store same", 1, ST, 2, 32'h2B);
    step("R9 cond fails", 1, SC, 2, 32'h2C);
    step("R6 load", 1, LD, 2, '0);
    step("R4 link", 1, LL, 4, '0);
    step("R10 snoop other", 0, LD, 0, '0, 1, 7, 32'h77);
    step("R10 cond ok", 1, SC, 4, 32'h44);
    step("R10 load snoop addr", 1, LD, 7, '0);
    step("R4 link", 1, LL, 4, '0);
    step("R10 snoop same", 0, LD, 0, '0, 1, 4, 32'h4F);
    step("R10 cond fails", 1, SC, 4, 32'h40);
    step("R10 load", 1, LD, 4, '0);
    step("R4 link", 1, LL, 8, '0);
    step("R11 cond with snoop", 1, SC, 8, 32'h80, 1, 8, 32'h8F);
    step("R11 snoop data kept", 1, LD, 8, '0);
    step("R11 store with snoop", 1, ST, 9, 32'h90, 1, 9, 32'h9F);
    step("R11 local data kept", 1, LD, 9, '0);
    step("R4 link", 1, LL, 1, '0);
    step("R12 link replace", 1, LL, 10, '0);
    step("R12 old fails", 1, SC, 1, 32'h10);
    step("R4 link", 1, LL, 1, '0);
    step("R12 link replace", 1, LL, 10, '0);
    step("R12 new ok", 1, SC, 10, 32'hA0);
    step("R13 link with snoop", 1, LL, 11, '0, 1, 11, 32'hBB);
    step("R13 cond fails", 1, SC, 11, 32'hB0);
    step("R13 load", 1, LD, 11, '0);
    for (int i = 0; i < 400; i++) begin
      step("R2 random", ($urandom % 4) != 0, 2'($urandom), int'($urandom % 4),
           $urandom, ($urandom % 3) == 0, int'($urandom % 4), $urandom);
    end
    for (int i = 0; i < DEPTH; i++) step("R2 sweep", 1, LD, i, '0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule